// File: doc/BRIEF.md
# Tracking Error Fault Monitor

This block watches the signed tracking error of two independent angle-tracking loops and reports, on one active-low flag, whether the loop picked by a channel select can be trusted. A low flag means the position word of that channel must be treated as invalid. Each channel has its own qualifier. A channel that has just come out of reset reports a fault until its loop has settled. A channel in normal operation reports a fault only when its error has stayed large for at least one whole reference period. Once faulted, a channel returns to normal when its error has fallen well below the level that set the fault. The gap between the set and clear levels keeps the flag from chattering near the threshold.

The error words come from the loops, in units of one position LSB. A one-cycle strobe marks each period of the excitation reference. A loop that is driven beyond its maximum tracking rate builds up an error that keeps growing. That error passes the set level and stays there, so an overspeed condition is reported through the same path as any other persistent tracking loss.

Top module: `trk_fault_mon`

## Requirements
- R1: `fault_n` is active low (0 = data invalid). It shows channel A when `sel_a` is 1 and channel B when `sel_a` is 0. It is a combinational function of the selected channel's registered state and responds within the same cycle.
- R2: While `rst_n` is low, and after it is released, both channels are in a startup state in which they report a fault.
- R3: A channel leaves startup only after its error magnitude has been below CLR_THR (default 45) at SETTLE_TICKS (default 4) consecutive `ref_tick` samples. Any cycle with a magnitude of CLR_THR or more restarts the count. The flag goes high after the edge that samples the last of these ticks.
- R4: A settled channel enters the fault state after the edge that samples the PERSIST_TICKS-th (default 2) `ref_tick` at which its magnitude exceeds SET_THR (default 55). The magnitude must stay above SET_THR for the whole of that interval.
- R5: In any cycle in which the magnitude of a settled channel is SET_THR or less, its persistence count returns to zero.
- R6: A channel in the fault state (not startup) returns to normal at the next clock edge at which its magnitude is below CLR_THR. No `ref_tick` is needed for this.
- R7: A magnitude from CLR_THR to SET_THR inclusive leaves a channel's reported state unchanged.
- R8: The magnitude is the absolute value of the two's-complement error, so positive and negative errors of the same size act alike. The most negative code counts as the largest magnitude.
- R9: Each channel keeps its own state whatever the select does. After a select change, the flag shows the newly chosen channel's state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_a | input | ERR_W | Signed tracking error of channel A, in LSBs |
| err_b | input | ERR_W | Signed tracking error of channel B, in LSBs |
| sel_a | input | 1 | Channel select: 1 = A, 0 = B |
| ref_tick | input | 1 | One-cycle strobe, once per reference period |
| fault_n | output | 1 | Fault flag of the selected channel, low = invalid |

## Verification
The assertions assume that `ref_tick` is a single-cycle strobe and that the error words are stable around each clock edge. They do not assume that the ticks are spaced evenly. They also assume the same tick is shared by both channels. The stimulus changes inputs only on the falling edge. It fires the tick at random, in isolated or back-to-back cycles. It draws errors from four groups: inside the clear level, inside the hysteresis band, just above the set level, and anywhere in the full signed range including the most negative code. As a result, every state transition and the hold band are hit many times in both signs.

// File: rtl/trk_fault_pkg.sv
package trk_fault_pkg;

  // per-channel qualifier state
  typedef enum logic [1:0] {
    CH_START = 2'd0,
    CH_OK    = 2'd1,
    CH_FAULT = 2'd2
  } ch_state_e;

endpackage

// File: rtl/tfm_mag.sv
// Error magnitude and threshold comparison for one channel.
module tfm_mag #(
  parameter int ERR_W   = 16,
  parameter int SET_THR = 55,
  parameter int CLR_THR = 45
) (
  input  logic signed [ERR_W-1:0] err,
  output logic [ERR_W-1:0]        mag,
  output logic                    over,
  output logic                    under
);

  localparam logic [ERR_W-1:0] SET_V = ERR_W'(SET_THR);
  localparam logic [ERR_W-1:0] CLR_V = ERR_W'(CLR_THR);
  localparam logic [ERR_W-1:0] MOST_NEG = {1'b1, {(ERR_W-1){1'b0}}};
  localparam logic [ERR_W-1:0] MOST_POS = {1'b0, {(ERR_W-1){1'b1}}};

  // absolute value, most negative code saturates to the largest positive
  function automatic logic [ERR_W-1:0] abs_sat(input logic signed [ERR_W-1:0] v);
    logic [ERR_W-1:0] u;
    u = v;
    if (!u[ERR_W-1])
      return u;
    else if (u == MOST_NEG)
      return MOST_POS;
    else
      return ERR_W'(~u + 1'b1);
  endfunction

  assign mag   = abs_sat(err);
  assign over  = (mag > SET_V);
  assign under = (mag < CLR_V);

endmodule

// File: rtl/tfm_chan.sv
// Per-channel qualifier: startup settling, persistence, hysteresis.
module tfm_chan
  import trk_fault_pkg::*;
#(
  parameter int PERSIST_TICKS = 2,
  parameter int SETTLE_TICKS  = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      over,
  input  logic      under,
  output ch_state_e state,
  output logic      faulted,
  output logic      in_start
);

  localparam int PW = $clog2(PERSIST_TICKS + 1);
  localparam int SW = $clog2(SETTLE_TICKS + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PERSIST_TICKS - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SETTLE_TICKS - 1);

  logic [PW-1:0] pers_cnt;
  logic [SW-1:0] settle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= CH_START;
      pers_cnt   <= '0;
      settle_cnt <= '0;
    end else begin
      case (state)
        CH_START: begin
          pers_cnt <= '0;
          if (!under) begin
            settle_cnt <= '0;
          end else if (tick) begin
            if (settle_cnt == S_LAST) begin
              state      <= CH_OK;
              settle_cnt <= '0;
            end else begin
              settle_cnt <= settle_cnt + 1'b1;
            end
          end
        end
        CH_OK: begin
          settle_cnt <= '0;
          if (!over) begin
            pers_cnt <= '0;
          end else if (tick) begin
            if (pers_cnt == P_LAST) begin
              state    <= CH_FAULT;
              pers_cnt <= '0;
            end else begin
              pers_cnt <= pers_cnt + 1'b1;
            end
          end
        end
        CH_FAULT: begin
          pers_cnt   <= '0;
          settle_cnt <= '0;
          if (under) state <= CH_OK;
        end
        default: begin
          state      <= CH_START;
          pers_cnt   <= '0;
          settle_cnt <= '0;
        end
      endcase
    end
  end

  assign faulted  = (state != CH_OK);
  assign in_start = (state == CH_START);

endmodule

// File: rtl/trk_fault_mon.sv
// Two-channel tracking error fault monitor, active-low selected flag.
module trk_fault_mon
  import trk_fault_pkg::*;
#(
  parameter int ERR_W         = 16,
  parameter int SET_THR       = 55,
  parameter int CLR_THR       = 45,
  parameter int PERSIST_TICKS = 2,
  parameter int SETTLE_TICKS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ERR_W-1:0] err_a,
  input  logic signed [ERR_W-1:0] err_b,
  input  logic                    sel_a,
  input  logic                    ref_tick,
  output logic                    fault_n
);

  localparam int NCH = 2;

  logic signed [ERR_W-1:0] err_v [NCH];
  logic [ERR_W-1:0]        ch_mag [NCH];
  ch_state_e               ch_state [NCH];

  // named per-channel events for the checker
  logic [NCH-1:0] ch_over;
  logic [NCH-1:0] ch_under;
  logic [NCH-1:0] ch_flt;
  logic [NCH-1:0] ch_start;

  assign err_v[0] = err_a;
  assign err_v[1] = err_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tfm_mag #(
      .ERR_W  (ERR_W),
      .SET_THR(SET_THR),
      .CLR_THR(CLR_THR)
    ) u_mag (
      .err  (err_v[c]),
      .mag  (ch_mag[c]),
      .over (ch_over[c]),
      .under(ch_under[c])
    );

    tfm_chan #(
      .PERSIST_TICKS(PERSIST_TICKS),
      .SETTLE_TICKS (SETTLE_TICKS)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ref_tick),
      .over    (ch_over[c]),
      .under   (ch_under[c]),
      .state   (ch_state[c]),
      .faulted (ch_flt[c]),
      .in_start(ch_start[c])
    );
  end

  // index 0 = channel A, index 1 = channel B
  assign fault_n = ~(sel_a ? ch_flt[0] : ch_flt[1]);

endmodule

// File: rtl/trk_fault_mon_chk.sv
module trk_fault_mon_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ref_tick,
  input logic           sel_a,
  input logic           fault_n,
  input logic [NCH-1:0] ch_over,
  input logic [NCH-1:0] ch_under,
  input logic [NCH-1:0] ch_flt,
  input logic [NCH-1:0] ch_start
);

  // R2: a selected channel in startup must show a fault
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_a && ch_start[0]) || (!sel_a && ch_start[1])) |-> !fault_n);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R3: leaving startup needs an under-threshold tick sample
    p_settle_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_start[i]) |-> ($past(ch_under[i]) && $past(ref_tick)));

    // R4: a new fault needs an over-threshold tick sample
    p_persist_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_flt[i]) |-> ($past(ch_over[i]) && $past(ref_tick)));

    // R6: a faulted, settled channel clears as soon as it is under
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_flt[i] && !ch_start[i] && ch_under[i]) |=> !ch_flt[i]);

    // R7: the hysteresis band holds the reported state
    p_hold_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_over[i] && !ch_under[i]) |=> $stable(ch_flt[i]));
  end

endmodule

bind trk_fault_mon trk_fault_mon_chk #(.NCH(2)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_tick(ref_tick),
  .sel_a   (sel_a),
  .fault_n (fault_n),
  .ch_over (ch_over),
  .ch_under(ch_under),
  .ch_flt  (ch_flt),
  .ch_start(ch_start)
);

// File: tb/trk_fault_mon_tb_top.sv
`timescale 1ns/1ps
module trk_fault_mon_tb_top;

  localparam int EW = 16;
  localparam int SET_T = 55;
  localparam int CLR_T = 45;
  localparam int PERS = 2;
  localparam int SETL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [EW-1:0] err_a = '0;
  logic signed [EW-1:0] err_b = '0;
  logic sel_a = 1'b1;
  logic ref_tick = 1'b0;
  logic fault_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trk_fault_mon dut_i (
    .clk(clk), .rst_n(rst_n), .err_a(err_a), .err_b(err_b),
    .sel_a(sel_a), .ref_tick(ref_tick), .fault_n(fault_n)
  );

  // ---------- independent reference model ----------
  // mode: 0 settling, 1 good, 2 bad
  int md [2];
  int pc [2];
  int sc [2];

  function automatic int size_of(input logic signed [EW-1:0] e);
    int v;
    v = int'(e);
    return (v < 0) ? -v : v;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      int m;
      m = size_of(k == 0 ? err_a : err_b);
      if (!rst_n) begin
        md[k] = 0; pc[k] = 0; sc[k] = 0;
      end else if (md[k] == 0) begin
        if (m >= CLR_T) sc[k] = 0;
        else if (ref_tick) begin
          sc[k] = sc[k] + 1;
          if (sc[k] >= SETL) begin md[k] = 1; sc[k] = 0; end
        end
      end else if (md[k] == 1) begin
        if (m <= SET_T) pc[k] = 0;
        else if (ref_tick) begin
          pc[k] = pc[k] + 1;
          if (pc[k] >= PERS) begin md[k] = 2; pc[k] = 0; end
        end
      end else begin
        if (m < CLR_T) md[k] = 1;
      end
    end
  end

  function automatic logic model_flag(input logic s);
    return (md[s ? 0 : 1] == 1);
  endfunction

  task automatic check(input string req, input logic expv);
    total++;
    if (fault_n !== expv) begin
      bad++;
      $display("FAIL %s: fault_n=%b expected=%b at %0t", req, fault_n, expv, $time);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, sample at the next fall
  task automatic step(input int ea, input int eb, input bit tk);
    err_a = EW'(ea);
    err_b = EW'(eb);
    ref_tick = tk;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    step(10, 100, 1);
    step(10, 100, 1);
    check("R2 reset A", 1'b0);
    sel_a = 1'b0; #1;
    check("R2 reset B", 1'b0);
    sel_a = 1'b1;
    rst_n = 1'b1;

    // R3: settling
    step(10, 100, 1); check("R3 tick1", 1'b0);
    step(10, 100, 1); check("R3 tick2", 1'b0);
    step(10, 100, 1); check("R3 tick3", 1'b0);
    step(50, 100, 1); check("R3 restart", 1'b0);
    step(10, 100, 1);
    step(-10, 100, 1);
    step(10, 100, 0); check("R3 no tick", 1'b0);
    step(10, 100, 1); check("R3 third after restart", 1'b0);
    step(10, 100, 1); check("R3 settled", 1'b1);

    // R4/R5: persistence
    step(60, 100, 1); check("R4 one tick", 1'b1);
    step(60, 100, 0);
    step(60, 100, 0); check("R4 no tick", 1'b1);
    step(55, 100, 1); check("R5 at set level", 1'b1);
    step(60, 100, 1); check("R5 count restarted", 1'b1);
    step(60, 100, 1); check("R4 set", 1'b0);

    // R7/R6 hysteresis
    step(50, 100, 1); check("R7 band holds fault", 1'b0);
    step(45, 100, 1); check("R7 clear level holds fault", 1'b0);
    step(-44, 100, 0); check("R6 clear", 1'b1);
    step(-50, 100, 1);
    step(-55, 100, 1); check("R7 band holds good", 1'b1);

    // R8: negative and most negative magnitudes
    step(-32768, 100, 1); check("R8 most negative one tick", 1'b1);
    step(-32768, 100, 1); check("R8 most negative set", 1'b0);
    step(0, 100, 0); check("R6 clear from neg", 1'b1);
    step(-56, 100, 1);
    step(-56, 100, 1); check("R8 negative set", 1'b0);
    step(3, 100, 0); check("R6 clear again", 1'b1);

    // R9 / R1: select switching
    sel_a = 1'b0; #1;
    check("R9 B still settling", 1'b0);
    sel_a = 1'b1; #1;
    check("R1 A shown", 1'b1);
    #1;

    // random phase, model-checked
    for (int n = 0; n < 4000; n++) begin
      int ea, eb;
      for (int k = 0; k < 2; k++) begin
        int r, v;
        r = int'($urandom % 6);
        case (r)
          0, 1, 2: v = int'($urandom % 45);
          3:       v = 45 + int'($urandom % 11);
          4:       v = 56 + int'($urandom % 150);
          default: v = int'($urandom % 32768);
        endcase
        if ($urandom % 2) v = -v;
        if (($urandom % 200) == 0) v = -32768;
        if (k == 0) ea = v; else eb = v;
      end
      sel_a = ($urandom % 2) == 1;
      step(ea, eb, ($urandom % 3) == 0);
      check("R4/R6/R7 random model", model_flag(sel_a));
      sel_a = ~sel_a; #1;
      check("R9 random switch", model_flag(sel_a));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: fault_n=%b expected=end of run", fault_n);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
  end

endmodule